// File: doc/BRIEF.md
# Binary Instruction First-Pass Translator

This block turns a run of 32-bit instructions from a 32-register RISC source instruction set into operations for a wide-issue target core. It does no scheduling. It fetches the source words one at a time from an instruction memory with a combinational read port. It splits each word into its opcode, register and immediate fields. It writes the matching target operations one per cycle into an output buffer.

A source instruction with no direct target counterpart is expanded into two target operations. The branch-if-negative instruction becomes a compare into a reserved temporary register, followed by a branch-if-zero on that temporary. Every jump and call also writes a pair of addresses into a boundary memory: the address of the instruction and the address it transfers to. A later pass uses these pairs to find basic-block edges.

Software starts a run with a base byte address and an instruction count. It waits for the done flag, then reads the operation and boundary totals and a sticky error flag. The error flag is set when an opcode is not recognised.

Top module: `fpt_translator`

## Requirements
- R1: After reset, done_o, err_o, op_valid_o and bnd_we_o are low, and op_cnt_o and bnd_cnt_o are zero.
- R2: Source fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], 16-bit immediate/offset [15:0] and jump index [25:0]. Target operations are opc [31:25], dst [24:19], src_a [18:13], src_b [12:7], imm [6:0]. Source register n maps to target register n.
- R3: Source ADD (6'h01) and SUB (6'h02) each emit exactly one operation: target 7'h01 or 7'h02 with dst=rd, src_a=rs, src_b=rt, imm=0. Source NOP (6'h00) emits one all-zero operation.
- R4: Source ADDI (6'h08) emits target 7'h03 with dst=rt, src_a=rs, src_b=0, imm=immediate[6:0].
- R5: Source BEQ (6'h09) emits target 7'h06 with dst=0, src_a=rs, src_b=rt, imm=offset[6:0].
- R6: Source BLTZ (6'h0A) emits two operations on consecutive cycles. The first is compare 7'h04 with dst=63, src_a=rs, src_b=0, imm=0. The second is branch-if-zero 7'h05 with dst=0, src_a=63, src_b=0, imm=offset[6:0].
- R7: Source J (6'h04) emits target 7'h07 with dst=0 and imm=index[6:0]. Source JAL (6'h05) emits target 7'h08 with dst=31 and imm=index[6:0].
- R8: In the same cycle as a J or JAL operation, bnd_we_o pulses and the boundary outputs are set. bnd_src_o is the instruction's byte address. bnd_dst_o is {address[31:28], index, 2'b00}. bnd_addr_o runs 0, 1, 2… within a run.
- R9: Operations leave one per cycle with no gaps, beginning the cycle after start is accepted. op_addr_o runs 0, 1, 2… within a run. Instruction i is fetched from base_i + 4*i.
- R10: Any other opcode emits one all-zero operation and sets err_o. err_o stays set until the next start.
- R11: The cycle after the last operation, done_o rises. op_cnt_o then holds the number of emitted operations and bnd_cnt_o the number of logged pairs. A count of zero gives done_o one cycle after start with both totals zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; accepted when idle or done |
| base_i | input | 32 | Byte address of the first source instruction |
| count_i | input | CNT_W | Number of source instructions |
| imem_addr_o | output | 32 | Fetch byte address |
| imem_rdata_i | input | 32 | Source instruction at imem_addr_o, same cycle |
| op_valid_o | output | 1 | Write strobe for the output buffer |
| op_addr_o | output | CNT_W+1 | Output buffer index |
| op_data_o | output | 32 | Target operation |
| bnd_we_o | output | 1 | Write strobe for the boundary memory |
| bnd_addr_o | output | CNT_W | Boundary memory index |
| bnd_src_o | output | 32 | Address of the jump or call |
| bnd_dst_o | output | 32 | Transfer destination address |
| done_o | output | 1 | Run complete; held until the next start |
| err_o | output | 1 | Sticky unrecognised-opcode flag |
| op_cnt_o | output | CNT_W+1 | Operations emitted in this run |
| bnd_cnt_o | output | CNT_W | Boundary pairs logged in this run |

## Verification
A fault in the fetch pointer or the remaining-count register shows up in the first cycle it is wrong. The operation stream drifts away from the expected words, or done_o rises too early or too late. A fault in the temporary-operand holding register corrupts the second operation of an expansion in the cycle straight after the compare. Faults in the operation or boundary index counters show at the next strobe, as a skipped or repeated address. The bench checks every cycle of each run against a queue of expected operations and boundary pairs, so any of these faults is caught in the cycle it first reaches a port.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int unsigned TREG_W = 6;
  localparam logic [TREG_W-1:0] TMP_REG = 6'd63;
  localparam logic [TREG_W-1:0] LINK_REG = 6'd31;

  // source opcodes
  localparam logic [5:0] S_NOP  = 6'h00;
  localparam logic [5:0] S_ADD  = 6'h01;
  localparam logic [5:0] S_SUB  = 6'h02;
  localparam logic [5:0] S_J    = 6'h04;
  localparam logic [5:0] S_JAL  = 6'h05;
  localparam logic [5:0] S_ADDI = 6'h08;
  localparam logic [5:0] S_BEQ  = 6'h09;
  localparam logic [5:0] S_BLTZ = 6'h0A;

  // target opcodes
  localparam logic [6:0] T_NOP   = 7'h00;
  localparam logic [6:0] T_ADD   = 7'h01;
  localparam logic [6:0] T_SUB   = 7'h02;
  localparam logic [6:0] T_ADDI  = 7'h03;
  localparam logic [6:0] T_CMPLT = 7'h04;
  localparam logic [6:0] T_BRZ   = 7'h05;
  localparam logic [6:0] T_BEQ   = 7'h06;
  localparam logic [6:0] T_GOTO  = 7'h07;
  localparam logic [6:0] T_CALL  = 7'h08;

  typedef struct packed {
    logic [6:0]        opc;
    logic [TREG_W-1:0] dst;
    logic [TREG_W-1:0] src_a;
    logic [TREG_W-1:0] src_b;
    logic [6:0]        imm;
  } top_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SECOND, ST_DONE} st_e;
endpackage

// File: rtl/fpt_decode.sv
module fpt_decode
  import fpt_pkg::*;
(
  input  logic [31:0] instr_i,
  output top_t        op0_o,
  output top_t        op1_o,
  output logic        two_ops_o,
  output logic        is_xfer_o,
  output logic        illegal_o,
  output logic [25:0] xfer_idx_o
);
  logic [5:0]        opcode;
  logic [TREG_W-1:0] rs, rt, rd;
  logic [6:0]        imm_lo;

  assign opcode     = instr_i[31:26];
  assign rs         = {1'b0, instr_i[25:21]};
  assign rt         = {1'b0, instr_i[20:16]};
  assign rd         = {1'b0, instr_i[15:11]};
  assign imm_lo     = instr_i[6:0];
  assign xfer_idx_o = instr_i[25:0];

  always_comb begin
    op0_o     = '0;
    op1_o     = '0;
    two_ops_o = 1'b0;
    is_xfer_o = 1'b0;
    illegal_o = 1'b0;
    unique case (opcode)
      S_NOP:  ;
      S_ADD:  op0_o = '{opc: T_ADD,  dst: rd, src_a: rs, src_b: rt, imm: '0};
      S_SUB:  op0_o = '{opc: T_SUB,  dst: rd, src_a: rs, src_b: rt, imm: '0};
      S_ADDI: op0_o = '{opc: T_ADDI, dst: rt, src_a: rs, src_b: '0, imm: imm_lo};
      S_BEQ:  op0_o = '{opc: T_BEQ,  dst: '0, src_a: rs, src_b: rt, imm: imm_lo};
      S_BLTZ: begin
        op0_o     = '{opc: T_CMPLT, dst: TMP_REG, src_a: rs, src_b: '0, imm: '0};
        op1_o     = '{opc: T_BRZ,   dst: '0, src_a: TMP_REG, src_b: '0, imm: imm_lo};
        two_ops_o = 1'b1;
      end
      S_J: begin
        op0_o     = '{opc: T_GOTO, dst: '0, src_a: '0, src_b: '0, imm: imm_lo};
        is_xfer_o = 1'b1;
      end
      S_JAL: begin
        op0_o     = '{opc: T_CALL, dst: LINK_REG, src_a: '0, src_b: '0, imm: imm_lo};
        is_xfer_o = 1'b1;
      end
      default: illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    a_r6_xfer_never_expands: assert (!(two_ops_o && is_xfer_o));
    a_r10_illegal_single_nop: assert (!illegal_o || (op0_o == '0 && !two_ops_o));
  end
endmodule

// File: rtl/fpt_seq.sv
module fpt_seq
  import fpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      base_i,
  input  logic [CNT_W-1:0] count_i,
  input  top_t             op0_i,
  input  top_t             op1_i,
  input  logic             two_ops_i,
  input  logic             is_xfer_i,
  input  logic             illegal_i,
  input  logic [25:0]      xfer_idx_i,
  output logic [31:0]      pc_o,
  output logic             op_valid_o,
  output logic [CNT_W:0]   op_addr_o,
  output logic [31:0]      op_data_o,
  output logic             bnd_we_o,
  output logic [CNT_W-1:0] bnd_addr_o,
  output logic [31:0]      bnd_src_o,
  output logic [31:0]      bnd_dst_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned OPC_W = CNT_W + 1;

  st_e              st_q;
  logic [31:0]      pc_q;
  logic [CNT_W-1:0] remain_q;
  logic [OPC_W-1:0] op_cnt_q;
  logic [CNT_W-1:0] bnd_cnt_q;
  top_t             hold_q;
  logic             err_q;
  logic             accept, last;

  assign accept = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign last   = (remain_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pc_q      <= '0;
      remain_q  <= '0;
      op_cnt_q  <= '0;
      bnd_cnt_q <= '0;
      hold_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          pc_q      <= base_i;
          remain_q  <= count_i;
          op_cnt_q  <= '0;
          bnd_cnt_q <= '0;
          err_q     <= 1'b0;
          st_q      <= (count_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          op_cnt_q <= op_cnt_q + OPC_W'(1);
          if (is_xfer_i) bnd_cnt_q <= bnd_cnt_q + CNT_W'(1);
          if (illegal_i) err_q <= 1'b1;
          if (two_ops_i) begin
            hold_q <= op1_i;
            st_q   <= ST_SECOND;
          end else begin
            pc_q     <= pc_q + 32'd4;
            remain_q <= remain_q - CNT_W'(1);
            st_q     <= last ? ST_DONE : ST_RUN;
          end
        end
        ST_SECOND: begin
          op_cnt_q <= op_cnt_q + OPC_W'(1);
          pc_q     <= pc_q + 32'd4;
          remain_q <= remain_q - CNT_W'(1);
          st_q     <= last ? ST_DONE : ST_RUN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pc_o       = pc_q;
  assign op_valid_o = (st_q == ST_RUN) || (st_q == ST_SECOND);
  assign op_data_o  = (st_q == ST_SECOND) ? hold_q : op0_i;
  assign op_addr_o  = op_cnt_q;
  assign bnd_we_o   = (st_q == ST_RUN) && is_xfer_i;
  assign bnd_addr_o = bnd_cnt_q;
  assign bnd_src_o  = pc_q;
  assign bnd_dst_o  = {pc_q[31:28], xfer_idx_i, 2'b00};
  assign done_o     = (st_q == ST_DONE);
  assign err_o      = err_q;

  a_r9_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !accept) |=> (!op_valid_o || op_addr_o == $past(op_addr_o) + OPC_W'(1)));
  a_r6_brz_follows_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_data_o[31:25] == T_CMPLT) |=>
      (op_valid_o && op_data_o[31:25] == T_BRZ && op_data_o[18:13] == TMP_REG));
  a_r8_bnd_with_xfer_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_we_o |-> (op_valid_o && (op_data_o[31:25] == T_GOTO || op_data_o[31:25] == T_CALL)));
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !accept) |=> err_o);
  a_r11_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!op_valid_o && !bnd_we_o));
endmodule

// File: rtl/fpt_translator.sv
module fpt_translator
  import fpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      base_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [31:0]      imem_addr_o,
  input  logic [31:0]      imem_rdata_i,
  output logic             op_valid_o,
  output logic [CNT_W:0]   op_addr_o,
  output logic [31:0]      op_data_o,
  output logic             bnd_we_o,
  output logic [CNT_W-1:0] bnd_addr_o,
  output logic [31:0]      bnd_src_o,
  output logic [31:0]      bnd_dst_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W:0]   op_cnt_o,
  output logic [CNT_W-1:0] bnd_cnt_o
);
  top_t        op0, op1;
  logic        two_ops, is_xfer, illegal;
  logic [25:0] xfer_idx;

  fpt_decode u_dec (
    .instr_i    (imem_rdata_i),
    .op0_o      (op0),
    .op1_o      (op1),
    .two_ops_o  (two_ops),
    .is_xfer_o  (is_xfer),
    .illegal_o  (illegal),
    .xfer_idx_o (xfer_idx)
  );

  fpt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .base_i     (base_i),
    .count_i    (count_i),
    .op0_i      (op0),
    .op1_i      (op1),
    .two_ops_i  (two_ops),
    .is_xfer_i  (is_xfer),
    .illegal_i  (illegal),
    .xfer_idx_i (xfer_idx),
    .pc_o       (imem_addr_o),
    .op_valid_o (op_valid_o),
    .op_addr_o  (op_addr_o),
    .op_data_o  (op_data_o),
    .bnd_we_o   (bnd_we_o),
    .bnd_addr_o (bnd_addr_o),
    .bnd_src_o  (bnd_src_o),
    .bnd_dst_o  (bnd_dst_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign op_cnt_o  = op_addr_o;
  assign bnd_cnt_o = bnd_addr_o;
endmodule

// File: tb/fpt_translator_tb.sv
`timescale 1ns/1ps
module fpt_translator_tb;
  localparam int CW = 16;
  localparam logic [31:0] MEM_BASE = 32'h4000_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base = '0;
  logic [CW-1:0] count = '0;
  logic [31:0] imem_addr, imem_rdata;
  logic op_valid, bnd_we, done, err;
  logic [CW:0] op_addr, op_cnt;
  logic [31:0] op_data, bnd_src, bnd_dst;
  logic [CW-1:0] bnd_addr, bnd_cnt;

  logic [31:0] mem [0:63];
  logic [31:0] word_off;

  int checks = 0, fails = 0;

  logic [31:0] q_op[$];
  logic        q_bwe[$];
  logic [31:0] q_bsrc[$];
  logic [31:0] q_bdst[$];
  string       q_tag[$];
  int exp_ops, exp_bnd;
  logic exp_err;

  always #4 clk = ~clk;

  assign word_off   = (imem_addr - MEM_BASE) >> 2;
  assign imem_rdata = mem[word_off[5:0]];

  fpt_translator #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .count_i(count),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .op_valid_o(op_valid), .op_addr_o(op_addr), .op_data_o(op_data),
    .bnd_we_o(bnd_we), .bnd_addr_o(bnd_addr), .bnd_src_o(bnd_src), .bnd_dst_o(bnd_dst),
    .done_o(done), .err_o(err), .op_cnt_o(op_cnt), .bnd_cnt_o(bnd_cnt)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {op, rs, rt, rd, 11'h0};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] top(logic [6:0] o, logic [5:0] d, logic [5:0] a, logic [5:0] b, logic [6:0] im);
    return {o, d, a, b, im};
  endfunction

  task automatic push(input logic [31:0] op, input logic bwe, input logic [31:0] s, input logic [31:0] d, input string tag);
    q_op.push_back(op); q_bwe.push_back(bwe); q_bsrc.push_back(s); q_bdst.push_back(d); q_tag.push_back(tag);
  endtask

  // behavioural reference
  task automatic model(input logic [31:0] b, input int n);
    exp_ops = 0; exp_bnd = 0; exp_err = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] pc, w;
      logic [5:0] rs, rt, rd;
      pc = b + 32'(4 * i);
      w  = mem[(pc - MEM_BASE) >> 2];
      rs = {1'b0, w[25:21]}; rt = {1'b0, w[20:16]}; rd = {1'b0, w[15:11]};
      case (w[31:26])
        6'h00: push(32'h0, 0, 0, 0, "R3 nop");
        6'h01: push(top(7'h01, rd, rs, rt, 0), 0, 0, 0, "R3 add");
        6'h02: push(top(7'h02, rd, rs, rt, 0), 0, 0, 0, "R3 sub");
        6'h08: push(top(7'h03, rt, rs, 0, w[6:0]), 0, 0, 0, "R4 addi");
        6'h09: push(top(7'h06, 0, rs, rt, w[6:0]), 0, 0, 0, "R5 beq");
        6'h0A: begin
          push(top(7'h04, 63, rs, 0, 0), 0, 0, 0, "R6 cmp");
          push(top(7'h05, 0, 63, 0, w[6:0]), 0, 0, 0, "R6 brz");
        end
        6'h04: begin
          push(top(7'h07, 0, 0, 0, w[6:0]), 1, pc, {pc[31:28], w[25:0], 2'b00}, "R7/R8 goto");
          exp_bnd++;
        end
        6'h05: begin
          push(top(7'h08, 31, 0, 0, w[6:0]), 1, pc, {pc[31:28], w[25:0], 2'b00}, "R7/R8 call");
          exp_bnd++;
        end
        default: begin
          push(32'h0, 0, 0, 0, "R10 illegal");
          exp_err = 1'b1;
        end
      endcase
    end
    exp_ops = q_op.size();
  endtask

  task automatic run(input logic [31:0] b, input int n);
    int idx = 0;
    int bidx = 0;
    model(b, n);
    @(negedge clk);
    start = 1'b1; base = b; count = CW'(n);
    @(negedge clk);
    start = 1'b0;
    while (q_op.size() != 0) begin
      logic [31:0] eop, es, ed;
      logic ebw;
      string t;
      eop = q_op.pop_front(); ebw = q_bwe.pop_front();
      es = q_bsrc.pop_front(); ed = q_bdst.pop_front(); t = q_tag.pop_front();
      chk(op_valid === 1'b1, {t, " R9 valid"}, 32'(op_valid), 1);
      chk(op_data === eop, t, op_data, eop);
      chk(op_addr === (CW+1)'(idx), "R9 op_addr", 32'(op_addr), 32'(idx));
      chk(bnd_we === ebw, "R8 bnd_we", 32'(bnd_we), 32'(ebw));
      if (ebw) begin
        chk(bnd_src === es, "R8 bnd_src", bnd_src, es);
        chk(bnd_dst === ed, "R8 bnd_dst", bnd_dst, ed);
        chk(bnd_addr === CW'(bidx), "R8 bnd_addr", 32'(bnd_addr), 32'(bidx));
        bidx++;
      end
      idx++;
      @(negedge clk);
    end
    chk(done === 1'b1, "R11 done", 32'(done), 1);
    chk(op_valid === 1'b0, "R11 quiet", 32'(op_valid), 0);
    chk(op_cnt === (CW+1)'(exp_ops), "R11 op_cnt", 32'(op_cnt), 32'(exp_ops));
    chk(bnd_cnt === CW'(exp_bnd), "R11 bnd_cnt", 32'(bnd_cnt), 32'(exp_bnd));
    chk(err === exp_err, "R10 err", 32'(err), 32'(exp_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    // program A at word 0: direct mappings (R2 R3 R4 R5)
    mem[0]  = enc_r(6'h01, 5'd1, 5'd2, 5'd3);
    mem[1]  = enc_r(6'h02, 5'd5, 5'd6, 5'd4);
    mem[2]  = enc_i(6'h08, 5'd8, 5'd7, 16'h01FF);
    mem[3]  = enc_i(6'h09, 5'd1, 5'd2, 16'h0085);
    mem[4]  = 32'h0;
    mem[5]  = enc_r(6'h01, 5'd31, 5'd30, 5'd29);
    // program B at word 8: expansion and transfers (R6 R7 R8)
    mem[8]  = enc_i(6'h0A, 5'd9, 5'd0, 16'h0043);
    mem[9]  = enc_r(6'h02, 5'd10, 5'd11, 5'd12);
    mem[10] = enc_j(6'h04, 26'h0123456);
    mem[11] = enc_j(6'h05, 26'h00000FF);
    mem[12] = enc_i(6'h0A, 5'd31, 5'd0, 16'hFFFF);
    mem[13] = enc_i(6'h0A, 5'd1, 5'd0, 16'h0001);
    // program C at word 16: unknown opcode (R10)
    mem[16] = 32'hFC00_0000;
    mem[17] = enc_r(6'h01, 5'd2, 5'd3, 5'd4);
    mem[18] = enc_j(6'h04, 26'h3FFFFFF);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done === 1'b0, "R1 done", 32'(done), 0);
    chk(err === 1'b0, "R1 err", 32'(err), 0);
    chk(op_valid === 1'b0, "R1 op_valid", 32'(op_valid), 0);
    chk(bnd_we === 1'b0, "R1 bnd_we", 32'(bnd_we), 0);
    chk(op_cnt === '0, "R1 op_cnt", 32'(op_cnt), 0);
    chk(bnd_cnt === '0, "R1 bnd_cnt", 32'(bnd_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && op_valid === 1'b0, "R1 idle after reset", 32'({done, op_valid}), 0);

    run(MEM_BASE, 6);
    run(MEM_BASE + 32'd32, 6);
    run(MEM_BASE + 32'd64, 3);
    // R10 error clears on the next start
    run(MEM_BASE + 32'd4, 2);
    // R11 zero-length run
    run(MEM_BASE, 0);
    // back-to-back from done state, expansion at the final word (R6 R9)
    run(MEM_BASE + 32'd48, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule